// File: doc/BRIEF.md
# Flash Self-Reprogramming Mode Register

This block is an 8-bit control and status register that sits between a CPU bus and an on-chip flash engine. It decides when software may reprogram the flash. Software writes the register to enter rewrite mode, to allow erase/write of the user block, to hold the flash controller in reset, and to choose between the boot and user ROM areas. The flash engine reports back through a busy level and two one-cycle failure pulses, for program and for erase.

Two bits are protected against accidental setting. Rewrite mode is armed only when a write of 0 is followed by a write of 1 on the next bus write. The user-block enable follows the same rule and can only be written while rewrite mode is already set. The reset bit works only under rewrite mode. Leaving rewrite mode clears every dependent bit at once.

Top module: `flash_rewrite_gate`

## Requirements
- R1: After reset, rd_data reads 0x01, rw_mode_o, blk_ew_en_o and ctl_rst_o are 0, and area_user_o is 1 while boot_strap is 0.
- R2: Bit 0 of rd_data reads 0 from the first clock edge that samples eng_busy high, and reads 1 from the first edge that samples it low. Writes to it have no effect.
- R3: Bit 1 (rewrite mode, mirrored on rw_mode_o) becomes 1 only when a write carrying bit 1 = 1 comes directly after a write carrying bit 1 = 0. A write of 1 without that preceding 0 leaves it unchanged. Any write with bit 1 = 0 clears it.
- R4: Bit 2 (user-block erase/write enable, mirrored on blk_ew_en_o) uses the same 0-then-1 rule. Writes to it are ignored while bit 1 is 0 before the write.
- R5: Bit 3 (controller reset) takes write data only while bit 1 is 1. ctl_rst_o equals bit 3 AND bit 1, delayed by one clock.
- R6: A write that clears bit 1 also clears bits 2 and 3 on the same edge, so ctl_rst_o falls one clock later.
- R7: Bit 4 always reads 0.
- R8: Bit 5 is stored on every write. area_user_o equals bit 5 while boot_strap is 1, and is 1 while boot_strap is 0.
- R9: Bit 6 sets on eng_prog_fail and bit 7 sets on eng_erase_fail. Each clears on the edge where eng_busy is first sampled high. If a failure pulse arrives in that same cycle, the set wins. Bus writes do not change either bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | One-cycle register write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Register read value |
| eng_busy | input | 1 | Flash engine busy level |
| eng_prog_fail | input | 1 | Program failure pulse |
| eng_erase_fail | input | 1 | Erase failure pulse |
| boot_strap | input | 1 | High when started in boot mode |
| rw_mode_o | output | 1 | Rewrite mode enable to engine |
| blk_ew_en_o | output | 1 | User-block erase/write enable |
| ctl_rst_o | output | 1 | Registered controller reset |
| area_user_o | output | 1 | 1 selects user ROM, 0 boot ROM |

## Verification
- **Register bits (bits 1, 2, 3, 5):** a write appears in rd_data right after the edge that samples the strobe. The bench drives inputs on falling edges and reads one falling edge later.
- **Bit 0 and the failure flags:** these change on the first edge that samples eng_busy or a failure pulse. The bench reads them at the next falling edge.
- **ctl_rst_o:** it has one more register stage. The bench therefore checks that it is still at its old value half a cycle after the write, and checks the new value one full cycle later.
- **area_user_o:** it is combinational from boot_strap and bit 5, so the bench checks it a short time after boot_strap changes.

// File: rtl/fgate_pkg.sv
package fgate_pkg;
   localparam int unsigned REG_W   = 8;
   localparam int unsigned B_READY = 0;
   localparam int unsigned B_MODE  = 1;
   localparam int unsigned B_BLKEW = 2;
   localparam int unsigned B_CRST  = 3;
   localparam int unsigned B_SPARE = 4;
   localparam int unsigned B_AREA  = 5;
   localparam int unsigned B_PFAIL = 6;
   localparam int unsigned B_EFAIL = 7;
   localparam int unsigned N_FLAGS = 2;
   localparam logic [REG_W-1:0] RESET_VAL = 8'h01;
endpackage

// File: rtl/fgate_arm_bit.sv
// One bit that is set only by a 0-then-1 pair of consecutive writes.
module fgate_arm_bit #(
   parameter bit GATED = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_en,
   input  logic wr_bit,
   input  logic allow_i,
   input  logic force_clr_i,
   output logic val_o
);
   logic val_q, primed_q, allow_eff;

   generate
      if (GATED) begin : g_gated
         assign allow_eff = allow_i;
      end else begin : g_free
         logic unused_allow;
         assign unused_allow = allow_i;
         assign allow_eff = 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         val_q    <= 1'b0;
         primed_q <= 1'b0;
      end else if (force_clr_i) begin
         val_q    <= 1'b0;
         primed_q <= 1'b0;
      end else if (wr_en) begin
         if (!allow_eff) begin
            primed_q <= 1'b0;
         end else if (!wr_bit) begin
            val_q    <= 1'b0;
            primed_q <= 1'b1;
         end else begin
            if (primed_q) val_q <= 1'b1;
            primed_q <= 1'b0;
         end
      end
   end

   assign val_o = val_q;

   // R3 / R4: a set always follows a primed write of 1
   p_set_needs_prime_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(val_q) |-> $past(wr_en && wr_bit && primed_q && allow_eff));
endmodule

// File: rtl/fgate_flag.sv
// Sticky failure flag: set by a pulse, cleared when a new operation starts.
module fgate_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic fail_i,
   input  logic start_i,
   output logic flag_o
);
   logic flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       flag_q <= 1'b0;
      else if (fail_i)  flag_q <= 1'b1;
      else if (start_i) flag_q <= 1'b0;
   end

   assign flag_o = flag_q;

   p_flag_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q) |-> $past(fail_i));
   p_flag_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag_q) |-> $past(start_i));
endmodule

// File: rtl/flash_rewrite_gate.sv
module flash_rewrite_gate
   import fgate_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   input  logic              eng_busy,
   input  logic              eng_prog_fail,
   input  logic              eng_erase_fail,
   input  logic              boot_strap,
   output logic              rw_mode_o,
   output logic              blk_ew_en_o,
   output logic              ctl_rst_o,
   output logic              area_user_o
);
   generate
      if (DATA_W != REG_W) begin : g_bad_width
         $error("flash_rewrite_gate: DATA_W must equal 8");
      end
   endgenerate

   logic mode_q, blk_q, rst_bit_q, area_q, busy_q, ctl_rst_q, mode_clr, op_start;
   logic [N_FLAGS-1:0] fail_in, flag_q;
   logic unused_wr_bits;

   assign unused_wr_bits = ^{wr_data[B_EFAIL], wr_data[B_PFAIL], wr_data[B_SPARE], wr_data[B_READY]};
   assign mode_clr = wr_en && !wr_data[B_MODE];
   assign op_start = eng_busy && !busy_q;

   fgate_arm_bit #(.GATED(1'b0)) u_mode (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bit(wr_data[B_MODE]),
      .allow_i(1'b1), .force_clr_i(1'b0), .val_o(mode_q));

   fgate_arm_bit #(.GATED(1'b1)) u_blkew (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bit(wr_data[B_BLKEW]),
      .allow_i(mode_q), .force_clr_i(mode_clr), .val_o(blk_q));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rst_bit_q <= 1'b0;
         area_q    <= 1'b0;
         busy_q    <= 1'b0;
         ctl_rst_q <= 1'b0;
      end else begin
         busy_q    <= eng_busy;
         ctl_rst_q <= rst_bit_q && mode_q;
         if (wr_en) area_q <= wr_data[B_AREA];
         if (mode_clr)             rst_bit_q <= 1'b0;
         else if (wr_en && mode_q) rst_bit_q <= wr_data[B_CRST];
      end
   end

   assign fail_in = {eng_erase_fail, eng_prog_fail};

   generate
      for (genvar i = 0; i < N_FLAGS; i++) begin : g_flag
         fgate_flag u_flag (
            .clk(clk), .rst_n(rst_n), .fail_i(fail_in[i]),
            .start_i(op_start), .flag_o(flag_q[i]));
      end
   endgenerate

   always_comb begin
      rd_data          = '0;
      rd_data[B_READY] = !busy_q;
      rd_data[B_MODE]  = mode_q;
      rd_data[B_BLKEW] = blk_q;
      rd_data[B_CRST]  = rst_bit_q;
      rd_data[B_AREA]  = area_q;
      rd_data[B_PFAIL] = flag_q[0];
      rd_data[B_EFAIL] = flag_q[1];
   end

   assign rw_mode_o   = mode_q;
   assign blk_ew_en_o = blk_q;
   assign ctl_rst_o   = ctl_rst_q;
   assign area_user_o = boot_strap ? area_q : 1'b1;

   p_ew_under_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
      blk_q |-> mode_q);
   p_rst_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_rst_o |-> $past(rst_bit_q && mode_q));
   p_mode_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mode_q) |-> (!blk_q && !rst_bit_q));
endmodule

// File: tb/flash_rewrite_gate_test.sv
`timescale 1ns/1ps
module flash_rewrite_gate_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] rd_data;
   logic       eng_busy = 1'b0, eng_prog_fail = 1'b0, eng_erase_fail = 1'b0;
   logic       boot_strap = 1'b0;
   logic       rw_mode_o, blk_ew_en_o, ctl_rst_o, area_user_o;
   int         n_tests = 0;
   int         n_fail = 0;

   always #4 clk = ~clk;

   flash_rewrite_gate uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
      .eng_busy(eng_busy), .eng_prog_fail(eng_prog_fail), .eng_erase_fail(eng_erase_fail),
      .boot_strap(boot_strap), .rw_mode_o(rw_mode_o), .blk_ew_en_o(blk_ew_en_o),
      .ctl_rst_o(ctl_rst_o), .area_user_o(area_user_o));

   task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_data = 8'h00;
   endtask

   task automatic t_reset();
      chk("R1 reset rd_data", rd_data, 8'h01);
      chk("R1 reset outputs", {4'b0, rw_mode_o, blk_ew_en_o, ctl_rst_o, area_user_o}, 8'h01);
   endtask

   task automatic t_mode_arm();
      wr(8'h02);
      chk("R3 stray 1 ignored", rd_data, 8'h01);
      wr(8'h00); wr(8'h00); wr(8'h02);
      chk("R3 0-then-1 sets mode", rd_data, 8'h03);
      chk("R3 rw_mode_o", {7'b0, rw_mode_o}, 8'h01);
      wr(8'h00);
      chk("R3 write 0 clears", rd_data, 8'h01);
   endtask

   task automatic t_blk_ew();
      wr(8'h00); wr(8'h04);
      chk("R4 ignored without mode", rd_data, 8'h01);
      wr(8'h00); wr(8'h02); wr(8'h06);
      chk("R4 unprimed 1 ignored", rd_data, 8'h03);
      wr(8'h02); wr(8'h06);
      chk("R4 0-then-1 sets bit2", rd_data, 8'h07);
      chk("R4 blk_ew_en_o", {7'b0, blk_ew_en_o}, 8'h01);
   endtask

   task automatic t_ctl_reset();
      wr(8'h0E);
      chk("R5 bit3 written", rd_data, 8'h0F);
      chk("R5 output not yet", {7'b0, ctl_rst_o}, 8'h00);
      @(negedge clk);
      chk("R5 output one clock later", {7'b0, ctl_rst_o}, 8'h01);
      wr(8'h00);
      chk("R6 clear drops bits 2,3", rd_data, 8'h01);
      chk("R6 blk_ew_en_o low", {7'b0, blk_ew_en_o}, 8'h00);
      @(negedge clk);
      chk("R6 ctl_rst_o falls", {7'b0, ctl_rst_o}, 8'h00);
      wr(8'h08);
      chk("R5 bit3 ignored w/o mode", rd_data, 8'h01);
      @(negedge clk);
      chk("R5 output stays low", {7'b0, ctl_rst_o}, 8'h00);
   endtask

   task automatic t_spare_area();
      wr(8'h00); wr(8'h10);
      chk("R7 bit4 reads 0", rd_data, 8'h01);
      wr(8'hF0);
      chk("R9 R8 writes to flags ignored, bit5 stored", rd_data, 8'h21);
      boot_strap = 1'b0; #1;
      chk("R8 non-boot selects user", {7'b0, area_user_o}, 8'h01);
      boot_strap = 1'b1; #1;
      chk("R8 boot bit5=1 user", {7'b0, area_user_o}, 8'h01);
      wr(8'h00);
      chk("R8 boot bit5=0 boot area", {7'b0, area_user_o}, 8'h00);
      boot_strap = 1'b0; #1;
      chk("R8 strap low ignores bit5", {7'b0, area_user_o}, 8'h01);
   endtask

   task automatic t_status();
      wr(8'h00);
      @(negedge clk); eng_busy = 1'b1;
      @(negedge clk);
      chk("R2 busy reads 0", rd_data, 8'h00);
      eng_prog_fail = 1'b1;
      @(negedge clk); eng_prog_fail = 1'b0;
      chk("R9 program fail sets bit6", rd_data, 8'h40);
      eng_erase_fail = 1'b1;
      @(negedge clk); eng_erase_fail = 1'b0;
      chk("R9 erase fail sets bit7", rd_data, 8'hC0);
      eng_busy = 1'b0;
      @(negedge clk);
      chk("R2 ready reads 1", rd_data, 8'hC1);
      wr(8'h00);
      chk("R9 write leaves flags", rd_data, 8'hC1);
      eng_busy = 1'b1;
      @(negedge clk);
      chk("R9 new op clears flags", rd_data, 8'h00);
      eng_busy = 1'b0;
      @(negedge clk);
      eng_busy = 1'b1; eng_erase_fail = 1'b1;
      @(negedge clk); eng_erase_fail = 1'b0;
      chk("R9 set wins over start", rd_data, 8'h80);
      eng_busy = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_mode_arm();
      t_blk_ew();
      t_ctl_reset();
      t_spare_area();
      t_status();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule